// File: doc/BRIEF.md
# Masked Interrupt Pending Aggregator

The block gathers eight device interrupt lines into one request line to the processor. Devices raise and drop pending lines with bit-vector strobes: a post strobe sets every pending bit that is high in its vector, and a clear strobe drops every bit that is high in its vector. Software sees two byte-wide registers. The first is a mask register, where a 1 blocks a line. The second is a pending register, which software reads raw. Software releases one line at a time by writing its number to an acknowledge port.

Internally the mask is held as an enable set, the bitwise inverse of what software writes. The request line is a register. It is recomputed at every clock edge from the next values of the pending and enable sets, so a change to either is visible on the request line at the same edge that stores the change. Priority resolution, vector generation, cascading and trigger-type programming are not part of this block.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst` is high, at each clock edge the pending set is cleared, every line is masked (the mask reads back 0xFF), `irq` goes low and `cfg_rvalid` goes low.
- R2: A write with `cfg_sel`=0 stores the byte as the mask. A 1 bit blocks that line. A later mask read returns the byte exactly as written.
- R3: A read with `cfg_rsel`=1 returns the pending set whatever the mask holds.
- R4: Each bit set in `dev_post` sets the matching pending bit at the next edge. Other bits keep their value.
- R5: Each bit set in `dev_clear` clears the matching pending bit at the next edge. When a post and a clear name the same bit in one cycle, the clear wins.
- R6: A write with `cfg_sel`=1 and `cfg_wdata[3:0]` in 0..7 clears the pending bit with that index. Bits 7:4 of the data are ignored.
- R7: A write with `cfg_sel`=1 and `cfg_wdata[3:0]` in 8..15 leaves the pending set unchanged.
- R8: After every edge, `irq` is high exactly when the pending set ANDed with the enabled lines is nonzero. It rises and falls at the same edge that stores the change.
- R9: `cfg_re` returns the selected register on `cfg_rdata`, with `cfg_rvalid` high, one cycle later (0 = mask, 1 = pending). The value returned is the one held before any update made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Software write strobe |
| cfg_sel | input | 1 | Write target: 0 mask, 1 acknowledge |
| cfg_wdata | input | 8 | Write data |
| cfg_re | input | 1 | Software read strobe |
| cfg_rsel | input | 1 | Read source: 0 mask, 1 pending |
| cfg_rdata | output | 8 | Read data, registered |
| cfg_rvalid | output | 1 | Read data valid |
| dev_post | input | 8 | Device set vector |
| dev_clear | input | 8 | Device clear vector |
| irq | output | 1 | Request line to the processor |

## Verification
The properties assume that every strobe and data input is a settled, known value at each rising edge. They also assume that reset is held for at least one edge before any traffic. The bench changes inputs only on falling edges and holds reset for several cycles. Where a property needs a stimulus in isolation, its antecedent excludes concurrent posts, clears or mask writes, so overlapping traffic never breaks it. The random phase still drives overlapping post, clear, acknowledge and mask traffic, and checks that traffic against the reference model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    WSEL_MASK = 1'b0,
    WSEL_ACK  = 1'b1
  } wsel_e;

  typedef enum logic {
    RSEL_MASK = 1'b0,
    RSEL_PEND = 1'b1
  } rsel_e;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     post,
  input  logic [N-1:0]     clear,
  input  logic             ack_en,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [N-1:0]     pend_q,
  output logic [N-1:0]     pend_nx
);
  logic [N-1:0] ack_hit;

  // One decoder slice per line; indices beyond N-1 match nothing.
  for (genvar i = 0; i < N; i++) begin : g_ack
    assign ack_hit[i] = ack_en && (int'(ack_idx) == i);
  end

  // Post first, then device clear, then software acknowledge.
  always_comb begin
    pend_nx = ((pend_q | post) & ~clear) & ~ack_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nx;
  end
endmodule

// File: rtl/irq_enable_store.sv
module irq_enable_store #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q,
  output logic [N-1:0] en_nx
);
  // Stored inverted: a written 1 disables the line.
  always_comb begin
    en_nx = wr_en ? ~wdata : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nx;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_agg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_q,
  input  logic [N-1:0] pend_nx,
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] en_nx,
  input  logic         rd_en,
  input  logic         rd_sel,
  output logic         irq,
  output logic [N-1:0] rdata,
  output logic         rvalid
);
  logic irq_nx;
  logic [N-1:0] rd_mux;

  always_comb begin
    irq_nx = |(pend_nx & en_nx);
    rd_mux = (rd_sel == RSEL_PEND) ? pend_q : ~en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      irq    <= irq_nx;
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic         cfg_sel,
  input  logic [N-1:0] cfg_wdata,
  input  logic         cfg_re,
  input  logic         cfg_rsel,
  output logic [N-1:0] cfg_rdata,
  output logic         cfg_rvalid,
  input  logic [N-1:0] dev_post,
  input  logic [N-1:0] dev_clear,
  output logic         irq
);
  logic [N-1:0] pend_q, pend_nx, en_q, en_nx;
  logic mask_wr, ack_wr;

  assign mask_wr = cfg_we && (cfg_sel == WSEL_MASK);
  assign ack_wr  = cfg_we && (cfg_sel == WSEL_ACK);

  irq_pend_store #(.N(N), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .post(dev_post), .clear(dev_clear),
    .ack_en(ack_wr), .ack_idx(cfg_wdata[IDX_W-1:0]),
    .pend_q(pend_q), .pend_nx(pend_nx)
  );

  irq_enable_store #(.N(N)) u_en (
    .clk(clk), .rst(rst), .wr_en(mask_wr), .wdata(cfg_wdata),
    .en_q(en_q), .en_nx(en_nx)
  );

  irq_out_stage #(.N(N)) u_out (
    .clk(clk), .rst(rst), .pend_q(pend_q), .pend_nx(pend_nx),
    .en_q(en_q), .en_nx(en_nx), .rd_en(cfg_re), .rd_sel(cfg_rsel),
    .irq(irq), .rdata(cfg_rdata), .rvalid(cfg_rvalid)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_we,
  input logic         cfg_sel,
  input logic [N-1:0] cfg_wdata,
  input logic         cfg_re,
  input logic         cfg_rsel,
  input logic [N-1:0] cfg_rdata,
  input logic         cfg_rvalid,
  input logic [N-1:0] dev_post,
  input logic [N-1:0] dev_clear,
  input logic         irq,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] en_q
);
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!irq && pend_q == '0 && en_q == '0 && !cfg_rvalid)); // R1

  AST_POST_RAISES: assert property (@(posedge clk) disable iff (rst)
    (((dev_post & ~dev_clear & en_q) != '0) && !cfg_we) |=> irq); // R8

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (dev_clear != '0) |=> ((pend_q & $past(dev_clear)) == '0)); // R5

  AST_ACK_HIGH_NOP: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel && int'(cfg_wdata[IDX_W-1:0]) >= N &&
     dev_post == '0 && dev_clear == '0) |=> (pend_q == $past(pend_q))); // R7

  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && !cfg_rsel) |=> (cfg_rvalid && cfg_rdata == ~$past(en_q))); // R2

  AST_PEND_RAW: assert property (@(posedge clk) disable iff (rst)
    (cfg_re && cfg_rsel) |=> (cfg_rdata == $past(pend_q))); // R3
endmodule

bind irq_aggregator irq_aggregator_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cfg_re(cfg_re), .cfg_rsel(cfg_rsel),
  .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .dev_post(dev_post),
  .dev_clear(dev_clear), .irq(irq), .pend_q(pend_q), .en_q(en_q)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 0, cfg_sel = 0, cfg_re = 0, cfg_rsel = 0;
  logic [7:0] cfg_wdata = 0, dev_post = 0, dev_clear = 0;
  logic [7:0] cfg_rdata;
  logic       cfg_rvalid, irq;

  int checks = 0;
  int errors = 0;
  int m_pend = 0;   // model pending set
  int m_en   = 0;   // model enable set (inverse of mask)
  int m_rd   = 0;
  bit m_rv   = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_re(cfg_re), .cfg_rsel(cfg_rsel),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .dev_post(dev_post),
    .dev_clear(dev_clear), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, advance the model at the rising edge,
  // compare at the next falling edge.
  task automatic cyc(bit we, bit sel, int wd, bit re, bit rs,
                     int post, int clr, string req);
    int np;
    cfg_we = we; cfg_sel = sel; cfg_wdata = 8'(wd);
    cfg_re = re; cfg_rsel = rs; dev_post = 8'(post); dev_clear = 8'(clr);
    @(posedge clk);
    m_rv = re;
    if (re) m_rd = rs ? m_pend : (~m_en & 8'hFF);
    np = ((m_pend | post) & ~clr) & 8'hFF;
    if (we && sel && (wd & 15) < 8) np = np & ~(1 << (wd & 15));
    if (we && !sel) m_en = ~wd & 8'hFF;
    m_pend = np;
    @(negedge clk);
    chk({req, "/R8 irq"}, int'(irq), int'((m_pend & m_en) != 0));
    chk({req, "/R9 rvalid"}, int'(cfg_rvalid), int'(m_rv));
    if (m_rv) chk({req, "/R9 rdata"}, int'(cfg_rdata), m_rd);
  endtask

  task automatic rd_mask(string req);  cyc(0,0,0,1,0,0,0,req); endtask
  task automatic rd_pend(string req);  cyc(0,0,0,1,1,0,0,req); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rvalid", int'(cfg_rvalid), 0);
    rst = 1'b0;
    rd_mask("R1 mask all set");
    rd_pend("R1 pending zero");
    // R4 posts while masked: irq stays low, pending shows raw (R3)
    cyc(0,0,0,0,0,8'h05,0,"R4 post masked");
    rd_pend("R3 raw pending under mask");
    // R2 unmask bit 2
    cyc(1,0,8'hFB,0,0,0,0,"R2 unmask line2");
    rd_mask("R2 readback");
    // R6 ack line 2, upper bits ignored
    cyc(1,1,8'hF2,0,0,0,0,"R6 ack idx2");
    rd_pend("R6 pending after ack");
    // R7 high index ack
    cyc(1,1,8'h0A,0,0,0,0,"R7 ack idx10");
    rd_pend("R7 pending unchanged");
    // R5 post and clear same bit
    cyc(1,0,8'h00,0,0,0,0,"R2 unmask all");
    cyc(0,0,0,0,0,8'h30,8'h10,"R5 clear wins");
    rd_pend("R5 pending");
    cyc(0,0,0,0,0,0,8'hFF,"R5 clear all");
    // R9 read returns pre-update value with concurrent mask write
    cyc(1,0,8'h3C,1,0,0,0,"R9 read old mask");
    rd_mask("R9 new mask");
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      cyc($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,255),
          $urandom_range(0,1), $urandom_range(0,1),
          ($urandom_range(0,2) == 0) ? $urandom_range(0,255) : 0,
          ($urandom_range(0,3) == 0) ? $urandom_range(0,255) : 0,
          "R4/R5/R6 random");
    end
    // reset mid-traffic
    cyc(0,0,0,0,0,8'hFF,0,"R4 fill");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    m_pend = 0; m_en = 0;
    chk("R1 irq after reset", int'(irq), 0);
    rst = 1'b0;
    rd_pend("R1 pending after reset");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule